// File: doc/BRIEF.md
# Square-Wave Drive and Phase Reference Generator

This block runs on the fast oscillator clock. It makes a square wave that drives an RC filter at 1/32 of that clock. It also makes two delayed copies of that wave, which act as phase references for a chopper demodulator. A one-bit decision from a delta-sigma modulator picks which of the two references goes to the demodulator. A one-cycle strobe, issued once per drive period, clocks the modulator. The modulator therefore samples at the drive frequency.

A single free-running phase counter drives every output, so all the outputs stay locked to each other. The decision bit and the two delay settings are captured only on the last clock of each drive period. A change therefore reaches the outputs only at the start of the next period. Inside a period nothing moves except the counter, so the selected reference has no glitches.

Top module: `phase_drive_gen`

## Requirements
- R1: The drive output is high while the phase counter is 0 to 15 and low while it is 16 to 31. Its period is 32 clock cycles, and the counter steps by one every clock.
- R2: The sample strobe is high for exactly one clock per drive period, on counter value 31. The next clock starts a new period with the drive high.
- R3: Reference A is high whenever (counter − delay A) mod 32 is less than 16. Delay A is an unsigned 5-bit number of clock periods. A delay of 0 makes reference A equal to the drive.
- R4: Reference B follows the same rule as R3, using delay B.
- R5: The selected-reference output equals reference A during a period if the decision bit was 0 on the strobe clock of the previous period. It equals reference B if that decision bit was 1.
- R6: A change of the decision bit on any clock other than the strobe clock has no effect on the selected-reference output in that period or the next.
- R7: Both delays are captured on the strobe clock and held for the whole following period. A change of a delay input on any other clock has no effect on the references.
- R8: While reset is high, the counter is 0, the strobe is low, reference A is selected and both delays are 0. All four waveforms then read high. The first clock after reset is released advances the counter to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_bit | input | 1 | Modulator decision: 0 selects reference A, 1 selects reference B |
| ofs_a | input | PH_W | Delay of reference A, in clock periods |
| ofs_b | input | PH_W | Delay of reference B, in clock periods |
| drive_o | output | 1 | Square-wave drive for the RC filter |
| ref_a_o | output | 1 | Reference A |
| ref_b_o | output | 1 | Reference B |
| ref_sel_o | output | 1 | Reference chosen for the demodulator |
| sample_o | output | 1 | One-clock sampling strobe, once per period |

## Verification
The properties assume that reset is synchronous and that the counter leaves reset at zero. Given that, the strobe fixes the period boundary. Where a property ties the captured decision or the captured delays to the strobe, it also assumes that the inputs are valid on the strobe clock. The stimulus holds each period's decision and delays steady from the first clock of that period. In selected periods it then disturbs the inputs between clocks 10 and 20 and restores them well before the strobe, so the capture always sees the intended values. The delays range over 0, 1, half a period, the maximum value, and values where A and B are equal.

// File: rtl/phase_drive_pkg.sv
package phase_drive_pkg;

    localparam int DEF_PH_W = 5;
    localparam int NUM_REFS = 2;

    typedef enum logic {
        PICK_A = 1'b0,
        PICK_B = 1'b1
    } ref_pick_e;

    // High for the first half of a 2**w cycle period, starting at the given delay.
    function automatic logic half_wave(input logic [31:0] phase, input logic [31:0] delay, input int w);
        logic [31:0] diff;
        diff = (phase - delay) & ((32'd1 << w) - 32'd1);
        return diff < (32'd1 << (w - 1));
    endfunction

endpackage

// File: rtl/phase_drive_counter.sv
module phase_drive_counter #(
    parameter int PH_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase_o,
    output logic            last_o
);
    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_q + 1'b1;
    end

    assign phase_o = phase_q;
    assign last_o  = &phase_q;
endmodule

// File: rtl/phase_drive_capture.sv
module phase_drive_capture
    import phase_drive_pkg::*;
#(
    parameter int PH_W = 5,
    parameter int NREF = NUM_REFS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      last_i,
    input  logic                      dec_i,
    input  logic [NREF-1:0][PH_W-1:0] ofs_i,
    output ref_pick_e                 pick_o,
    output logic [NREF-1:0][PH_W-1:0] ofs_o
);
    ref_pick_e                 pick_q;
    logic [NREF-1:0][PH_W-1:0] ofs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pick_q <= PICK_A;
            ofs_q  <= '0;
        end else if (last_i) begin
            pick_q <= ref_pick_e'(dec_i);
            ofs_q  <= ofs_i;
        end
    end

    assign pick_o = pick_q;
    assign ofs_o  = ofs_q;
endmodule

// File: rtl/phase_drive_wave.sv
module phase_drive_wave
    import phase_drive_pkg::*;
#(
    parameter int PH_W = 5
) (
    input  logic [PH_W-1:0] phase_i,
    input  logic [PH_W-1:0] delay_i,
    output logic            wave_o
);
    always_comb begin
        wave_o = half_wave(32'(phase_i), 32'(delay_i), PH_W);
    end
endmodule

// File: rtl/phase_drive_gen.sv
module phase_drive_gen
    import phase_drive_pkg::*;
#(
    parameter int PH_W = DEF_PH_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dec_bit,
    input  logic [PH_W-1:0] ofs_a,
    input  logic [PH_W-1:0] ofs_b,
    output logic            drive_o,
    output logic            ref_a_o,
    output logic            ref_b_o,
    output logic            ref_sel_o,
    output logic            sample_o
);
    localparam int NREF = NUM_REFS;

    logic [PH_W-1:0]           phase;
    logic                      last;
    ref_pick_e                 sel_q;
    logic [NREF-1:0][PH_W-1:0] ofs_in;
    logic [NREF-1:0][PH_W-1:0] ofs_q;
    logic [NREF-1:0]           refs;

    assign ofs_in[0] = ofs_a;
    assign ofs_in[1] = ofs_b;

    phase_drive_counter #(.PH_W(PH_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase),
        .last_o  (last)
    );

    phase_drive_capture #(.PH_W(PH_W), .NREF(NREF)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .last_i (last),
        .dec_i  (dec_bit),
        .ofs_i  (ofs_in),
        .pick_o (sel_q),
        .ofs_o  (ofs_q)
    );

    phase_drive_wave #(.PH_W(PH_W)) u_drive (
        .phase_i (phase),
        .delay_i ('0),
        .wave_o  (drive_o)
    );

    for (genvar k = 0; k < NREF; k++) begin : g_ref
        phase_drive_wave #(.PH_W(PH_W)) u_ref (
            .phase_i (phase),
            .delay_i (ofs_q[k]),
            .wave_o  (refs[k])
        );
    end

    assign ref_a_o   = refs[0];
    assign ref_b_o   = refs[1];
    assign ref_sel_o = (sel_q == PICK_B) ? refs[1] : refs[0];
    assign sample_o  = last;
endmodule

// File: rtl/phase_drive_gen_chk.sv
module phase_drive_gen_chk #(
    parameter int PH_W = 5
) (
    input logic                clk,
    input logic                rst,
    input logic                dec_bit,
    input logic                drive_o,
    input logic                ref_a_o,
    input logic                sample_o,
    input logic                sel_q,
    input logic [2*PH_W-1:0]   ofs_q
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sample_o |=> !sample_o); // R2
    AST_DRIVE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        sample_o |=> drive_o); // R1
    AST_DRIVE_RISE_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_o) |-> $past(sample_o)); // R1
    AST_PICK_FOLLOWS_DEC: assert property (@(posedge clk) disable iff (rst)
        sample_o |=> (sel_q == $past(dec_bit))); // R5
    AST_PICK_HELD: assert property (@(posedge clk) disable iff (rst)
        !sample_o |=> $stable(sel_q)); // R6
    AST_DELAY_HELD: assert property (@(posedge clk) disable iff (rst)
        !sample_o |=> $stable(ofs_q)); // R7
    AST_REF_A_ZERO_DELAY: assert property (@(posedge clk) disable iff (rst)
        (ofs_q[PH_W-1:0] == '0) |-> (ref_a_o == drive_o)); // R3
endmodule

bind phase_drive_gen phase_drive_gen_chk #(.PH_W(PH_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dec_bit  (dec_bit),
    .drive_o  (drive_o),
    .ref_a_o  (ref_a_o),
    .sample_o (sample_o),
    .sel_q    (sel_q),
    .ofs_q    (ofs_q)
);

// File: tb/test_phase_drive_gen.sv
module test_phase_drive_gen;
    localparam int PH_W = 5;
    localparam int PER  = 32;

    typedef struct packed {
        logic drv;
        logic ra;
        logic rb;
        logic rs;
        logic smp;
        logic glitch;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dec_bit = 1'b0;
    logic [PH_W-1:0] ofs_a = '0;
    logic [PH_W-1:0] ofs_b = '0;
    logic drive_o, ref_a_o, ref_b_o, ref_sel_o, sample_o;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    logic cur_sel = 1'b0;
    logic [PH_W-1:0] cur_a = '0;
    logic [PH_W-1:0] cur_b = '0;

    always #5 clk = ~clk;

    phase_drive_gen #(.PH_W(PH_W)) i_phase_drive_gen (
        .clk       (clk),
        .rst       (rst),
        .dec_bit   (dec_bit),
        .ofs_a     (ofs_a),
        .ofs_b     (ofs_b),
        .drive_o   (drive_o),
        .ref_a_o   (ref_a_o),
        .ref_b_o   (ref_b_o),
        .ref_sel_o (ref_sel_o),
        .sample_o  (sample_o)
    );

    function automatic logic wave(input int c, input logic [PH_W-1:0] d);
        return ((c - int'(d)) & (PER - 1)) < (PER / 2);
    endfunction

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Driver: called on the falling edge where counter value 0 of a period is visible.
    task automatic run_period(input logic d, input logic [PH_W-1:0] a,
                              input logic [PH_W-1:0] b, input bit glitch);
        for (int c = 0; c < PER; c++) begin
            exp_t e;
            e.drv    = (c < PER / 2);
            e.ra     = wave(c, cur_a);
            e.rb     = wave(c, cur_b);
            e.rs     = cur_sel ? wave(c, cur_b) : wave(c, cur_a);
            e.smp    = (c == PER - 1);
            e.glitch = glitch;
            q.push_back(e);
        end
        dec_bit = d; ofs_a = a; ofs_b = b;
        for (int c = 0; c < PER; c++) begin
            if (c > 0) @(negedge clk);
            if (glitch && c == 10) begin
                dec_bit = ~d; ofs_a = a + 5'd7; ofs_b = b ^ 5'd5;
            end
            if (glitch && c == 20) begin
                dec_bit = d; ofs_a = a; ofs_b = b;
            end
        end
        cur_sel = d; cur_a = a; cur_b = b;
        @(negedge clk);
    endtask

    // Monitor: pops one expected item per clock and compares.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check1("R1 drive", drive_o, e.drv);
                check1("R2 strobe", sample_o, e.smp);
                check1(e.glitch ? "R3/R7 ref A" : "R3 ref A", ref_a_o, e.ra);
                check1(e.glitch ? "R4/R7 ref B" : "R4 ref B", ref_b_o, e.rb);
                check1(e.glitch ? "R5/R6 selected" : "R5 selected", ref_sel_o, e.rs);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check1("R8 drive in reset", drive_o, 1'b1);
        check1("R8 strobe in reset", sample_o, 1'b0);
        check1("R8 ref A in reset", ref_a_o, 1'b1);
        check1("R8 ref B in reset", ref_b_o, 1'b1);
        check1("R8 selected in reset", ref_sel_o, 1'b1);
        rst = 1'b0;
        run_period(1'b0, 5'd0,  5'd0,  1'b0);
        run_period(1'b1, 5'd3,  5'd8,  1'b0);
        run_period(1'b0, 5'd3,  5'd8,  1'b1);
        run_period(1'b1, 5'd31, 5'd16, 1'b1);
        run_period(1'b1, 5'd0,  5'd1,  1'b0);
        run_period(1'b0, 5'd15, 5'd17, 1'b1);
        run_period(1'b1, 5'd5,  5'd5,  1'b1);
        run_period(1'b0, 5'd16, 5'd0,  1'b0);
        run_period(1'b0, 5'd0,  5'd0,  1'b0);
        wait (q.size() == 0);
        @(negedge clk);
        #2;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule